// File: doc/BRIEF.md
# Dual-Clock Serial Field Delay Memory

This block is a serial-access store for one video field or frame. Words go in on a write clock and come out on a read clock, and the two clocks are unrelated. Neither port has an address bus. Each port keeps its own address pointer, which steps through the array one word per active cycle. A rewind strobe sends that pointer back to word zero. The delay between a word going in and the same word coming out is therefore set only by when the two rewinds occur. The block is used as a programmable delay line: for example, one field of delay, or picture-in-picture insertion, where only selected locations of a stored field are replaced.

Each port has two separate gating controls. The write port has `wr_valid` and `wr_store`:
- When `wr_valid` is low, the pointer stops.
- When `wr_store` is low, the array is left untouched, but the pointer still advances.

The read port has `rd_ready` and `rd_show`:
- When `rd_ready` is low, the pointer and the output stop.
- When `rd_show` is low, the output is blanked to zero with `rd_valid` low, but the pointer still advances.

Neither side applies back-pressure to the other. A write is always accepted. A read always returns whatever the array holds at the read pointer. No pointer is passed across the clock boundary.

The write port also reports two protocol errors as one-cycle pulses:
- a rewind strobe that rises again too soon after its previous high sample;
- a write sequence that was too short, meaning it had fewer than `MIN_ACTIVE` active cycles between two rewinds.

Top module: `field_delay_mem`

## Requirements
- R1: On a write-clock edge with `wr_rewind` high, the write pointer becomes 0 and nothing is stored, whatever the values of `wr_valid` and `wr_store`.
- R2: On a write-clock edge with `wr_rewind` low and `wr_valid` high, the pointer advances by one. When `wr_store` is also high, `wr_data` is first stored at the current pointer. With `wr_valid` low, the pointer holds and nothing is stored.
- R3: With `wr_store` low and `wr_valid` high, the addressed word keeps its old contents while the write pointer still advances.
- R4: Both pointers wrap from address DEPTH-1 to address 0.
- R5: On a read-clock edge with `rd_rewind` high, `rd_data` is loaded from word 0 at that same edge, with no extra latency, and the next read comes from word 1. The `rd_show` gating of R7 applies to this edge, and `rd_ready` is ignored.
- R6: On a read-clock edge with `rd_ready` low and `rd_rewind` low, the read pointer, `rd_data` and `rd_valid` all hold.
- R7: On an advancing read edge (`rd_ready` or `rd_rewind` high), `rd_show` low loads `rd_data` with 0 and `rd_valid` with 0, and the pointer still advances. With `rd_show` high, `rd_valid` becomes 1.
- R8: `wr_gap_err` is high for exactly the cycle after a write edge at which `wr_rewind` is sampled high, having been low at only the single previous edge and high at the edge before that.
- R9: `wr_short_err` is high for the cycle after a write edge at which `wr_rewind` rises, provided two conditions hold:
  - a rewind has been seen since reset;
  - fewer than MIN_ACTIVE cycles with `wr_valid` high and `wr_rewind` low occurred since the last high sample of `wr_rewind`.
- R10: While their port resets are asserted, the following are all 0: both pointers, `rd_data`, `rd_valid`, `wr_gap_err` and `wr_short_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| wr_rewind | input | 1 | Write pointer rewind strobe |
| wr_valid | input | 1 | Write advance enable (pointer stalls when low) |
| wr_store | input | 1 | Write mask (no store when low, pointer still moves) |
| wr_data | input | DW | Word to be written |
| wr_gap_err | output | 1 | Pulse: rewind re-raised after a single low cycle |
| wr_short_err | output | 1 | Pulse: write sequence shorter than MIN_ACTIVE |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| rd_rewind | input | 1 | Read pointer rewind strobe |
| rd_ready | input | 1 | Read advance enable (pointer and output stall when low) |
| rd_show | input | 1 | Output enable (zero output when low, pointer still moves) |
| rd_data | output | DW | Registered read word |
| rd_valid | output | 1 | High when `rd_data` carries a shown word |

## Verification
The assertions on the rewind flags assume that `wr_rewind` is held low during reset. The bench does this, so a history sampled during reset cannot fake a rising edge.

The array has no arbitration between ports, so a read of a word in the same window as a write to it is undefined. The stimulus therefore never overlaps write and read phases.

Array words are undefined until first written. For that reason, the bench fills every address before any read that it checks, and it only masks locations that already hold known data. Rewind pulses are driven at a range of spacings so that both the legal gap and the illegal gap, and both the short and long sequences, occur.

// File: rtl/fdm_pkg.sv
package fdm_pkg;

  // Decoded action of one write-clock edge
  typedef enum logic [1:0] {
    WR_IDLE_OP   = 2'd0,
    WR_SKIP_OP   = 2'd1,
    WR_STORE_OP  = 2'd2,
    WR_REWIND_OP = 2'd3
  } wr_op_e;

endpackage

// File: rtl/fdm_store.sv
module fdm_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rword
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // Unregistered read; the read port captures it
  assign rword = cells[raddr];

endmodule

// File: rtl/fdm_wr_port.sv
module fdm_wr_port #(
  parameter int DEPTH      = 1024,
  parameter int MIN_ACTIVE = 80,
  localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW        = $clog2(MIN_ACTIVE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rewind,
  input  logic          valid,
  input  logic          store,
  output logic          mem_we,
  output logic [AW-1:0] ptr,
  output logic          gap_err,
  output logic          short_err
);
  import fdm_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_ACTIVE);

  wr_op_e        op;
  logic [AW-1:0] ptr_inc;
  logic          hist1, hist2, armed, rise;
  logic [CW-1:0] act_cnt;

  always_comb begin
    if (rewind)      op = WR_REWIND_OP;
    else if (!valid) op = WR_IDLE_OP;
    else if (store)  op = WR_STORE_OP;
    else             op = WR_SKIP_OP;
  end

  assign ptr_inc = (ptr == LAST) ? '0 : ptr + AW'(1);
  assign mem_we  = (op == WR_STORE_OP);
  assign rise    = rewind & ~hist1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else begin
      unique case (op)
        WR_REWIND_OP:             ptr <= '0;
        WR_STORE_OP, WR_SKIP_OP:  ptr <= ptr_inc;
        default:                  ptr <= ptr;
      endcase
    end
  end

  // Rewind history, active-cycle count and protocol pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist1     <= 1'b0;
      hist2     <= 1'b0;
      armed     <= 1'b0;
      act_cnt   <= '0;
      gap_err   <= 1'b0;
      short_err <= 1'b0;
    end else begin
      hist1     <= rewind;
      hist2     <= hist1;
      armed     <= armed | rewind;
      gap_err   <= rise & hist2;
      short_err <= rise & armed & (act_cnt < CMAX);
      if (rewind)
        act_cnt <= '0;
      else if (valid && act_cnt != CMAX)
        act_cnt <= act_cnt + CW'(1);
    end
  end

endmodule

// File: rtl/fdm_rd_port.sv
module fdm_rd_port #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rewind,
  input  logic          ready,
  input  logic          show,
  input  logic [DW-1:0] word,
  output logic [AW-1:0] raddr,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] data,
  output logic          valid
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          step;
  logic [AW-1:0] raddr_inc;

  // A rewind reads word 0 at the same edge, so no latency is added
  assign raddr     = rewind ? '0 : ptr;
  assign step      = rewind | ready;
  assign raddr_inc = (raddr == LAST) ? '0 : raddr + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else if (step) begin
      ptr   <= raddr_inc;
      data  <= show ? word : '0;
      valid <= show;
    end
  end

endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem #(
  parameter int DW         = 8,
  parameter int DEPTH      = 1024,
  parameter int MIN_ACTIVE = 80,
  localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic          wr_rewind,
  input  logic          wr_valid,
  input  logic          wr_store,
  input  logic [DW-1:0] wr_data,
  output logic          wr_gap_err,
  output logic          wr_short_err,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  input  logic          rd_rewind,
  input  logic          rd_ready,
  input  logic          rd_show,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  logic          wr_we;
  logic [AW-1:0] wr_ptr_q;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] rd_ptr_q;
  logic [DW-1:0] rd_word;

  fdm_wr_port #(.DEPTH(DEPTH), .MIN_ACTIVE(MIN_ACTIVE)) u_wr (
    .clk       (wr_clk),
    .rst_n     (wr_rst_n),
    .rewind    (wr_rewind),
    .valid     (wr_valid),
    .store     (wr_store),
    .mem_we    (wr_we),
    .ptr       (wr_ptr_q),
    .gap_err   (wr_gap_err),
    .short_err (wr_short_err)
  );

  fdm_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .wr_clk (wr_clk),
    .we     (wr_we),
    .waddr  (wr_ptr_q),
    .wdata  (wr_data),
    .raddr  (rd_addr),
    .rword  (rd_word)
  );

  fdm_rd_port #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .clk    (rd_clk),
    .rst_n  (rd_rst_n),
    .rewind (rd_rewind),
    .ready  (rd_ready),
    .show   (rd_show),
    .word   (rd_word),
    .raddr  (rd_addr),
    .ptr    (rd_ptr_q),
    .data   (rd_data),
    .valid  (rd_valid)
  );

endmodule

// File: rtl/fdm_checker.sv
module fdm_checker #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          wr_rewind,
  input logic          wr_valid,
  input logic          wr_gap_err,
  input logic          wr_short_err,
  input logic [AW-1:0] wr_ptr,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_rewind,
  input logic          rd_ready,
  input logic          rd_show,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic [AW-1:0] rd_ptr
);

  AST_WR_REWIND_ZERO: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_rewind |=> wr_ptr == '0); // R1

  AST_WR_STALL_HOLD: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_rewind && !wr_valid |=> $stable(wr_ptr)); // R2

  AST_GAP_PULSE_CAUSE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_gap_err |-> $past(wr_rewind) && !$past(wr_rewind, 2)); // R8

  AST_SHORT_PULSE_CAUSE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_short_err |-> $past(wr_rewind) && !$past(wr_rewind, 2)); // R9

  AST_RD_REWIND_NEXT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_rewind |=> rd_ptr == ((DEPTH > 1) ? AW'(1) : '0)); // R5

  AST_RD_STALL_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_ready && !rd_rewind |=> $stable(rd_data) && $stable(rd_valid) && $stable(rd_ptr)); // R6

  AST_RD_BLANK: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_ready || rd_rewind) && !rd_show |=> rd_data == '0 && !rd_valid); // R7

  AST_RD_SHOWN_VALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_ready || rd_rewind) && rd_show |=> rd_valid); // R7

endmodule

bind field_delay_mem fdm_checker #(.DW(DW), .DEPTH(DEPTH)) u_fdm_chk (
  .wr_clk       (wr_clk),
  .wr_rst_n     (wr_rst_n),
  .wr_rewind    (wr_rewind),
  .wr_valid     (wr_valid),
  .wr_gap_err   (wr_gap_err),
  .wr_short_err (wr_short_err),
  .wr_ptr       (wr_ptr_q),
  .rd_clk       (rd_clk),
  .rd_rst_n     (rd_rst_n),
  .rd_rewind    (rd_rewind),
  .rd_ready     (rd_ready),
  .rd_show      (rd_show),
  .rd_data      (rd_data),
  .rd_valid     (rd_valid),
  .rd_ptr       (rd_ptr_q)
);

// File: tb/tb_field_delay_mem.sv
`timescale 1ns/1ps
module tb_field_delay_mem;

  localparam int DW    = 8;
  localparam int DEPTH = 32;
  localparam int MINA  = 8;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic          wr_rewind = 1'b0, wr_valid = 1'b0, wr_store = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_gap_err, wr_short_err;
  logic          rd_rewind = 1'b0, rd_ready = 1'b0, rd_show = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  field_delay_mem #(.DW(DW), .DEPTH(DEPTH), .MIN_ACTIVE(MINA)) dut (.*);

  always #2.5 wr_clk = ~wr_clk;
  initial begin
    #1.7;
    forever #2.5 rd_clk = ~rd_clk;
  end

  int checks = 0, fails = 0;
  bit done = 0;

  // Bench-side expectation state
  logic [DW-1:0] m_mem [DEPTH];
  int  m_wp = 0, m_rp = 0, m_cnt = 0;
  bit  m_h1 = 0, m_h2 = 0, m_armed = 0;
  logic [DW-1:0] m_rdata = '0;
  bit  m_rvalid = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 7 + 3) % 256);
  endfunction

  task automatic wstep(input bit rw, input bit v, input bit s, input logic [DW-1:0] d);
    bit rise, e_gap, e_short;
    @(negedge wr_clk);
    wr_rewind = rw; wr_valid = v; wr_store = s; wr_data = d;
    @(posedge wr_clk);
    #1;
    rise    = rw && !m_h1;
    e_gap   = rise && m_h2;
    e_short = rise && m_armed && (m_cnt < MINA);
    if (rw) begin
      m_wp = 0; m_cnt = 0;
    end else if (v) begin
      if (s) m_mem[m_wp] = d;
      m_wp = (m_wp + 1) % DEPTH;
      if (m_cnt < MINA) m_cnt++;
    end
    m_armed = m_armed || rw;
    m_h2 = m_h1; m_h1 = rw;
    check("R8 gap", {31'd0, wr_gap_err}, {31'd0, e_gap});
    check("R9 short", {31'd0, wr_short_err}, {31'd0, e_short});
  endtask

  task automatic rstep(input bit rw, input bit rdy, input bit sh);
    string tag;
    int a;
    @(negedge rd_clk);
    rd_rewind = rw; rd_ready = rdy; rd_show = sh;
    @(posedge rd_clk);
    #1;
    if (rw || rdy) begin
      a = rw ? 0 : m_rp;
      m_rdata  = sh ? m_mem[a] : '0;
      m_rvalid = sh;
      m_rp = (a + 1) % DEPTH;
      tag = rw ? "R5 rewind read" : (!sh ? "R7 blanked read" : "R2 R3 R4 read content");
    end else begin
      tag = "R6 stalled read";
    end
    check(tag, {24'd0, rd_data}, {24'd0, m_rdata});
    check(tag, {31'd0, rd_valid}, {31'd0, m_rvalid});
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    repeat (3) @(posedge wr_clk);
    #1;
    check("R10 rd_data", {24'd0, rd_data}, 32'd0);
    check("R10 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R10 gap", {31'd0, wr_gap_err}, 32'd0);
    check("R10 short", {31'd0, wr_short_err}, 32'd0);
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;

    // Fill every address, then one more write lands on word 0 by wrapping
    wstep(1, 0, 0, '0);
    for (int i = 0; i < DEPTH; i++) wstep(0, 1, 1, pat(i));
    wstep(0, 1, 1, 8'h5A);
    // Rewind with enables high must not store
    wstep(1, 1, 1, 8'hEE);
    rstep(1, 0, 1);
    check("R4 wrap wrote word0", {24'd0, rd_data}, 32'h5A);
    check("R1 rewind stored nothing", {31'd0, rd_data == 8'hEE}, 32'd0);
    rstep(0, 1, 1);
    check("R2 word1", {24'd0, rd_data}, {24'd0, pat(1)});

    // Mixed stall and mask pattern on writes
    for (int i = 0; i < 40; i++)
      wstep(0, (i % 3) != 0, (i % 4) != 1, DW'(8'h80 ^ (i * 5)));

    // Read sweep with stalls and blanking, crossing the wrap point
    rstep(1, 0, 1);
    for (int i = 0; i < 70; i++) rstep(0, (i % 5) != 2, (i % 7) != 3);
    rstep(1, 1, 0);
    rstep(0, 0, 1);

    // Rewind spacing and sequence-length errors
    wstep(1, 0, 0, '0);
    wstep(0, 1, 0, '0);
    wstep(1, 0, 0, '0);            // gap of one low cycle, short sequence
    wstep(0, 0, 0, '0);
    wstep(0, 0, 0, '0);
    wstep(1, 0, 0, '0);            // legal gap, still short
    wstep(1, 1, 1, 8'h11);         // held high: no new rise
    for (int i = 0; i < MINA; i++) wstep(0, 1, 0, 8'hFF);
    wstep(0, 1, 1, 8'h77);
    wstep(1, 0, 0, '0);            // long enough: no short pulse
    for (int i = 0; i < 3; i++) wstep(0, 1, 1, DW'(8'hC0 + i));
    for (int i = 0; i < MINA - 5; i++) wstep(0, 1, 0, '0);
    wstep(0, 0, 0, '0);
    wstep(0, 0, 0, '0);
    wstep(1, 0, 0, '0);            // MINA-2 active cycles: short

    rstep(1, 1, 1);
    for (int i = 0; i < DEPTH + 2; i++) rstep(0, 1, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule